// File: doc/BRIEF.md
# Per-Pad Function Multiplexer

This block connects a small bank of I/O pads to a larger set of single-wire functions. Every pad has its own configuration register. The register holds a select code and two pull-control bits. The select code picks which function drives the pad's output value. The same code also picks which function's output-enable sets the pad direction. In the other direction, the value seen on each pad is returned to whichever function that pad currently carries. When more than one pad carries the same function, the pad with the lowest index wins.

Each pad's own GPIO is an ordinary function held in select slot 0. Peripheral functions fill the slots above it according to a fixed pattern, and some slots stay empty. Bidirectional functions keep their incoming and outgoing wires separate; no tristate is formed inside the block. The first few peripheral functions make up a bus. Their direction is taken from a single shared bus enable, so every pad carrying a bus line turns around at the same moment.

Software writes the registers through an address / data / write-strobe port.

Top module: `pinmux_top`

## Requirements
- R1: After reset every pad select is 0 (GPIO slot) and every pad has pull-up and pull-down disabled.
- R2: A write with `cfg_we` high updates only the register of pad `cfg_addr`, and the new value is visible at the outputs from the clock edge that takes the write. The data layout is: bits [SEL_W-1:0] are the select, bit SEL_W is the pull-up enable, and bit SEL_W+1 is the pull-down enable. Registers of other pads keep their values.
- R3: Slot 0 of pad p routes `gpio_out[p]` to `pad_out[p]`. Slot s≥1 of pad p carries peripheral function p+s-1 when that index is below NUM_PFN, and routes `pfn_out` of that function to the pad.
- R4: The same select code routes the output-enable. Slot 0 uses `gpio_oe[p]`; a peripheral slot uses that function's enable.
- R5: A select code whose slot holds no function (p+s-1 ≥ NUM_PFN) drives `pad_out` to 0 and `pad_oe` to 0.
- R6: `pfn_in[f]` equals `pad_in` of the lowest-indexed pad whose select currently carries function f.
- R7: `pfn_in[f]` is 0 when no pad carries function f.
- R8: `gpio_in[p]` equals `pad_in[p]` when pad p selects slot 0, and is 0 otherwise.
- R9: For functions with index below BUS_W, the pad output-enable comes from `bus_oe`, and their own `pfn_oe` bits are ignored.
- R10: `pad_pu[p]` and `pad_pd[p]` follow the pad's pull bits independently of each other and of the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Pad register index |
| cfg_wdata | input | SEL_W+2 | {pull-down, pull-up, select} |
| gpio_out | input | NUM_PADS | GPIO output value per pad |
| gpio_oe | input | NUM_PADS | GPIO output-enable per pad |
| gpio_in | output | NUM_PADS | GPIO input value per pad |
| pfn_out | input | NUM_PFN | Peripheral function output values |
| pfn_oe | input | NUM_PFN | Peripheral function output-enables |
| bus_oe | input | 1 | Shared direction of the bus functions |
| pfn_in | output | NUM_PFN | Peripheral function input values |
| pad_in | input | NUM_PADS | Value sensed at each pad |
| pad_out | output | NUM_PADS | Value driven to each pad |
| pad_oe | output | NUM_PADS | Output-enable to each pad |
| pad_pu | output | NUM_PADS | Pull-up enable per pad |
| pad_pd | output | NUM_PADS | Pull-down enable per pad |

## Verification
The hardest case to reach is a contested function. Two pads must carry the same peripheral function, they must see different `pad_in` values, and a third pad must sit on an empty slot, all in the same cycle. The stimulus reaches this by writing pads 0 and 1 to slots that both map to function 1. It then drives opposite levels on those two pads and confirms that only pad 0's value arrives. After that, randomized register writes and input patterns are checked against a model of the slot pattern. These make claim overlaps and bus turnarounds appear in many combinations.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    // Slot decode codes shared by the routing logic and the checker.
    localparam int SLOT_GPIO  = -2;
    localparam int SLOT_EMPTY = -1;

    // Function held by slot `slot` of pad `pad`.
    // Returns SLOT_GPIO, SLOT_EMPTY, or a peripheral index.
    function automatic int slot_fn(input int pad, input int slot, input int num_pfn);
        int f;
        if (slot == 0) return SLOT_GPIO;
        f = pad + slot - 1;
        if (f < num_pfn) return f;
        return SLOT_EMPTY;
    endfunction

endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs #(
    parameter int NUM_PADS = 4,
    parameter int SEL_W    = 2,
    parameter int ADDR_W   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [SEL_W+1:0]                   wdata,
    output logic [NUM_PADS-1:0][SEL_W-1:0]     sel,
    output logic [NUM_PADS-1:0]                pu,
    output logic [NUM_PADS-1:0]                pd
);

    localparam int PU_BIT = SEL_W;
    localparam int PD_BIT = SEL_W + 1;

    typedef struct packed {
        logic [NUM_PADS-1:0][SEL_W-1:0] sel;
        logic [NUM_PADS-1:0]            pu;
        logic [NUM_PADS-1:0]            pd;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && (32'(addr) < NUM_PADS)) begin
            cfg_d.sel[addr] = wdata[SEL_W-1:0];
            cfg_d.pu[addr]  = wdata[PU_BIT];
            cfg_d.pd[addr]  = wdata[PD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sel = cfg_q.sel;
    assign pu  = cfg_q.pu;
    assign pd  = cfg_q.pd;

endmodule

// File: rtl/pinmux_pad_out.sv
module pinmux_pad_out
    import pinmux_pkg::*;
#(
    parameter int PAD     = 0,
    parameter int SEL_W   = 2,
    parameter int NUM_PFN = 4
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               gpio_o,
    input  logic               gpio_e,
    input  logic [NUM_PFN-1:0] pfn_o,
    input  logic [NUM_PFN-1:0] pfn_e,
    output logic               pad_o,
    output logic               pad_e
);

    localparam int NSLOT = 1 << SEL_W;

    logic [NSLOT-1:0] slot_o;
    logic [NSLOT-1:0] slot_e;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int F = slot_fn(PAD, s, NUM_PFN);
        if (F == SLOT_GPIO) begin : g_gpio
            assign slot_o[s] = gpio_o;
            assign slot_e[s] = gpio_e;
        end else if (F >= 0) begin : g_fn
            assign slot_o[s] = pfn_o[F];
            assign slot_e[s] = pfn_e[F];
        end else begin : g_empty
            assign slot_o[s] = 1'b0;
            assign slot_e[s] = 1'b0;
        end
    end

    // One address steers both value and direction.
    assign pad_o = slot_o[sel];
    assign pad_e = slot_e[sel];

endmodule

// File: rtl/pinmux_in_prio.sv
module pinmux_in_prio
    import pinmux_pkg::*;
#(
    parameter int NUM_PADS = 4,
    parameter int SEL_W    = 2,
    parameter int NUM_PFN  = 4
) (
    input  logic [NUM_PADS-1:0][SEL_W-1:0] sel,
    input  logic [NUM_PADS-1:0]            pad_in,
    output logic [NUM_PFN-1:0]             pfn_in,
    output logic [NUM_PADS-1:0]            gpio_in
);

    localparam int NSLOT = 1 << SEL_W;

    // Walk pads from high to low so the lowest claimant is applied last.
    always_comb begin
        pfn_in = '0;
        for (int f = 0; f < NUM_PFN; f++) begin
            for (int p = NUM_PADS - 1; p >= 0; p--) begin
                for (int s = 1; s < NSLOT; s++) begin
                    if (slot_fn(p, s, NUM_PFN) == f && sel[p] == SEL_W'(s))
                        pfn_in[f] = pad_in[p];
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_gpio_in
        assign gpio_in[p] = (sel[p] == '0) ? pad_in[p] : 1'b0;
    end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top #(
    parameter int NUM_PADS = 4,
    parameter int SEL_W    = 2,
    parameter int NUM_PFN  = 4,
    parameter int BUS_W    = 2,
    localparam int ADDR_W  = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [SEL_W+1:0]    cfg_wdata,
    input  logic [NUM_PADS-1:0] gpio_out,
    input  logic [NUM_PADS-1:0] gpio_oe,
    output logic [NUM_PADS-1:0] gpio_in,
    input  logic [NUM_PFN-1:0]  pfn_out,
    input  logic [NUM_PFN-1:0]  pfn_oe,
    input  logic                bus_oe,
    output logic [NUM_PFN-1:0]  pfn_in,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] pad_pu,
    output logic [NUM_PADS-1:0] pad_pd
);

    logic [NUM_PADS-1:0][SEL_W-1:0] sel;
    logic [NUM_PFN-1:0]             pfn_oe_eff;

    pinmux_cfg_regs #(
        .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .sel(sel), .pu(pad_pu), .pd(pad_pd)
    );

    // Bus members share one direction from the bus controller.
    for (genvar f = 0; f < NUM_PFN; f++) begin : g_dir
        if (f < BUS_W) begin : g_bus
            assign pfn_oe_eff[f] = bus_oe;
        end else begin : g_own
            assign pfn_oe_eff[f] = pfn_oe[f];
        end
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pinmux_pad_out #(
            .PAD(p), .SEL_W(SEL_W), .NUM_PFN(NUM_PFN)
        ) u_out (
            .sel(sel[p]), .gpio_o(gpio_out[p]), .gpio_e(gpio_oe[p]),
            .pfn_o(pfn_out), .pfn_e(pfn_oe_eff),
            .pad_o(pad_out[p]), .pad_e(pad_oe[p])
        );
    end

    pinmux_in_prio #(
        .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .NUM_PFN(NUM_PFN)
    ) u_in (
        .sel(sel), .pad_in(pad_in), .pfn_in(pfn_in), .gpio_in(gpio_in)
    );

endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk
    import pinmux_pkg::*;
#(
    parameter int NUM_PADS = 4,
    parameter int SEL_W    = 2,
    parameter int NUM_PFN  = 4,
    parameter int BUS_W    = 2,
    parameter int ADDR_W   = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [ADDR_W-1:0]              cfg_addr,
    input logic [SEL_W+1:0]               cfg_wdata,
    input logic [NUM_PADS-1:0][SEL_W-1:0] sel,
    input logic                           bus_oe,
    input logic [NUM_PADS-1:0]            pad_out,
    input logic [NUM_PADS-1:0]            pad_oe,
    input logic [NUM_PADS-1:0]            pad_pu,
    input logic [NUM_PADS-1:0]            pad_pd,
    input logic [NUM_PADS-1:0]            gpio_in,
    input logic [NUM_PFN-1:0]             pfn_in
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel == '0 && pad_pu == '0 && pad_pd == '0));

    logic [NUM_PADS-1:0] pad_empty;
    logic [NUM_PADS-1:0] pad_bus;
    logic [NUM_PFN-1:0]  claimed;

    always_comb begin
        claimed   = '0;
        pad_empty = '0;
        pad_bus   = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (slot_fn(p, int'(sel[p]), NUM_PFN) == SLOT_EMPTY) pad_empty[p] = 1'b1;
            for (int f = 0; f < NUM_PFN; f++) begin
                if (slot_fn(p, int'(sel[p]), NUM_PFN) == f) begin
                    claimed[f] = 1'b1;
                    if (f < BUS_W) pad_bus[p] = 1'b1;
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == ADDR_W'(p)) |=>
                (sel[p] == $past(cfg_wdata[SEL_W-1:0])
                 && pad_pu[p] == $past(cfg_wdata[SEL_W])
                 && pad_pd[p] == $past(cfg_wdata[SEL_W+1])));

        a_r2_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_addr == ADDR_W'(p)) |=>
                ($stable(sel[p]) && $stable(pad_pu[p]) && $stable(pad_pd[p])));

        a_r5_empty_is_input: assert property (@(posedge clk) disable iff (!rst_n)
            pad_empty[p] |-> (!pad_out[p] && !pad_oe[p]));

        a_r9_bus_direction: assert property (@(posedge clk) disable iff (!rst_n)
            pad_bus[p] |-> (pad_oe[p] == bus_oe));

        a_r8_gpio_parked: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[p] != '0) |-> !gpio_in[p]);
    end

    for (genvar f = 0; f < NUM_PFN; f++) begin : g_fn
        a_r7_unclaimed_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !claimed[f] |-> !pfn_in[f]);
    end

endmodule

bind pinmux_top pinmux_chk #(
    .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .NUM_PFN(NUM_PFN),
    .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel(sel), .bus_oe(bus_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .gpio_in(gpio_in), .pfn_in(pfn_in)
);

// File: tb/pinmux_top_tb.sv
`timescale 1ns/1ps
module pinmux_top_tb;

    localparam int NP = 4;
    localparam int SW = 2;
    localparam int NF = 4;
    localparam int BW = 2;
    localparam int CLK_NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [SW+1:0] cfg_wdata = '0;
    logic [NP-1:0] gpio_out = '0, gpio_oe = '0, gpio_in;
    logic [NF-1:0] pfn_out = '0, pfn_oe = '0, pfn_in;
    logic          bus_oe = 1'b0;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd;

    always #(CLK_NS/2) clk = ~clk;

    pinmux_top #(.NUM_PADS(NP), .SEL_W(SW), .NUM_PFN(NF), .BUS_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .gpio_in(gpio_in), .pfn_out(pfn_out), .pfn_oe(pfn_oe), .bus_oe(bus_oe),
        .pfn_in(pfn_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event  ev_sample;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    // Shadow configuration kept from the writes the bench issues.
    int sh_sel[NP];
    bit sh_pu[NP];
    bit sh_pd[NP];

    function automatic int fn_of(int p, int s);
        if (s == 0) return -2;
        if (p + s - 1 < NF) return p + s - 1;
        return -1;
    endfunction

    function automatic logic [31:0] observe(int kind);
        case (kind)
            0: return 32'(pad_out);
            1: return 32'(pad_oe);
            2: return 32'(pad_pu);
            3: return 32'(pad_pd);
            4: return 32'(pfn_in);
            default: return 32'(gpio_in);
        endcase
    endfunction

    function automatic string kind_req(int kind);
        case (kind)
            0: return "R3 pad_out";
            1: return "R4 pad_oe";
            2: return "R10 pad_pu";
            3: return "R10 pad_pd";
            4: return "R6 pfn_in";
            default: return "R8 gpio_in";
        endcase
    endfunction

    // Monitor: pops expected items and compares with the ports.
    initial begin
        forever begin
            @(ev_sample);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                got = observe(it.kind);
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s / %s: actual %0h expected %0h",
                             it.tag, kind_req(it.kind), got, it.exp);
                end
            end
        end
    end

    task automatic wr(int p, int s, bit pu, bit pd);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 2'(p);
        cfg_wdata = {pd, pu, SW'(s)};
        @(negedge clk);
        cfg_we    = 1'b0;
        sh_sel[p] = s;
        sh_pu[p]  = pu;
        sh_pd[p]  = pd;
    endtask

    // Driver: computes expectations from the requirements, pushes them.
    task automatic check(string tag);
        logic [NP-1:0] e_out, e_oe, e_pu, e_pd, e_gin;
        logic [NF-1:0] e_fin, seen;
        #1;
        e_out = '0; e_oe = '0; e_pu = '0; e_pd = '0; e_gin = '0;
        e_fin = '0; seen = '0;
        for (int p = 0; p < NP; p++) begin
            int f;
            f = fn_of(p, sh_sel[p]);
            e_pu[p] = sh_pu[p];
            e_pd[p] = sh_pd[p];
            if (f == -2) begin
                e_out[p] = gpio_out[p];
                e_oe[p]  = gpio_oe[p];
                e_gin[p] = pad_in[p];
            end else if (f >= 0) begin
                e_out[p] = pfn_out[f];
                e_oe[p]  = (f < BW) ? bus_oe : pfn_oe[f];
                if (!seen[f]) begin
                    seen[f]  = 1'b1;
                    e_fin[f] = pad_in[p];
                end
            end
        end
        q.push_back('{tag, 0, 32'(e_out)});
        q.push_back('{tag, 1, 32'(e_oe)});
        q.push_back('{tag, 2, 32'(e_pu)});
        q.push_back('{tag, 3, 32'(e_pd)});
        q.push_back('{tag, 4, 32'(e_fin)});
        q.push_back('{tag, 5, 32'(e_gin)});
        ->ev_sample;
        wait (q.size() == 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            sh_sel[p] = 0; sh_pu[p] = 0; sh_pd[p] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, GPIO on every pad
        gpio_out = 4'b1010; gpio_oe = 4'b0110; pad_in = 4'b1100;
        pfn_out = 4'b1111; pfn_oe = 4'b1111;
        check("R1 reset");
        // R7: nothing claimed, all function inputs low
        pad_in = 4'b1111;
        check("R7 unclaimed");

        // R3 R4 R9: every pad on slot 1 (functions 0..3), bus on 0 and 1
        for (int p = 0; p < NP; p++) wr(p, 1, 0, 0);
        pfn_out = 4'b0101; pfn_oe = 4'b1110; bus_oe = 1'b0;
        check("R9 bus low");
        bus_oe = 1'b1; pfn_oe = 4'b0000;
        check("R9 bus high");
        pad_in = 4'b0110;
        check("R6 single claims");

        // R6 R5: pads 0 and 1 both claim function 1; pads 2,3 on empty slots
        wr(0, 2, 0, 0); wr(1, 1, 0, 0); wr(2, 3, 0, 0); wr(3, 2, 0, 0);
        pfn_out = 4'b1111; pfn_oe = 4'b1111; bus_oe = 1'b1;
        pad_in = 4'b0001;
        check("R6 R5 contest pad0 high");
        pad_in = 4'b1110;
        check("R6 R5 contest pad0 low");

        // R10 R2: pulls independent, other pads keep their registers
        wr(2, 3, 1, 0);
        check("R10 R2 pu only");
        wr(3, 0, 0, 1);
        check("R10 R2 pd only");
        wr(1, 2, 1, 1);
        check("R10 R2 both");

        // Randomized writes and input patterns against the model.
        for (int i = 0; i < 60; i++) begin
            wr(int'($urandom_range(NP - 1)), int'($urandom_range(3)),
               1'($urandom), 1'($urandom));
            gpio_out = 4'($urandom); gpio_oe = 4'($urandom);
            pfn_out  = 4'($urandom); pfn_oe  = 4'($urandom);
            bus_oe   = 1'($urandom); pad_in  = 4'($urandom);
            check("R2 R3 R4 R6 random");
        end

        done = 1;
        summary();
    end

endmodule